// File: doc/BRIEF.md
# Narrow-to-Full Word Widener with Flag Detection

This block sits in front of a video serializer. The parallel source feeding it may carry only 8 meaningful bits per word. When `in_narrow` is high, each word is widened to 10 bits. The 8-bit value is moved up two places and zeros fill the new low bits. The one exception is the all-ones 8-bit value, which becomes the full-scale 10-bit value 3FF. This restores the first word of every timing preamble. Zero words stay zero, and the status word that follows a preamble is widened like any other word. When `in_narrow` is low, words pass through unchanged.

After widening, and in either mode, the block watches the stream for two markers. Any word in the range 3FC to 3FF counts as a high marker. Such a word raises an ancillary-flag pulse, because a narrow source cannot tell 3FC from 3FF. A high marker followed by two zero words is a timing preamble. All outputs are registered and appear one clock after the input word. Cycles with `in_valid` low are skipped by both the data path and the preamble tracker.

Top module: `wordup_flagger`

## Requirements
- R1: While `rst_n` is low, `out_word`, `out_valid`, `anc_flag` and `trs_found` are all 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: With `in_narrow` low, a valid word appears unchanged on `out_word` one clock later.
- R4: With `in_narrow` high, `out_word` is `in_word[7:0]` shifted left by two with bits [1:0] zero. `in_word[9:8]` has no effect.
- R5: With `in_narrow` high, an `in_word[7:0]` of FF produces 3FF on `out_word`.
- R6: `anc_flag` is high in the output cycle of every valid widened word in 3FC..3FF, including back-to-back flags, and is low otherwise.
- R7: `trs_found` is high in the output cycle of the third word of a valid sequence made of a word in 3FC..3FF, then 000, then 000. The 000 word is that output word. A first word below 3FC never starts a preamble.
- R8: Cycles with `in_valid` low do not break a preamble in progress, raise no flag, and leave `out_word` holding its previous value.
- R9: A nonzero word inside a partial preamble cancels it, and a high-range word always restarts it. After a completed preamble, a further zero does not report again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 10 | Incoming word; only bits [7:0] are used in narrow mode |
| in_valid | input | 1 | Marks `in_word` as a word of the stream |
| in_narrow | input | 1 | High when the source carries 8 meaningful bits |
| out_word | output | 10 | Widened word, one clock after input |
| out_valid | output | 1 | Registered copy of `in_valid` |
| anc_flag | output | 1 | Pulse with each output word in 3FC..3FF |
| trs_found | output | 1 | Pulse with the last zero of a timing preamble |

## Verification
The bench targets the boundary of the high range: 3FB against 3FC, and narrow FE against FF. A design that compared against 3FF alone would miss flags from 3FC..3FE. A design that shifted FF without the fix-up would emit 3FC at preamble starts. Preambles are split by idle cycles, broken by a nonzero word, restarted by a second high word, and followed by an extra zero. A tracker that resets on idle cycles, fails to restart, or keeps its final state would then miss a preamble or report a false one. Narrow-mode words with the top input bits set expose a widener that lets bits [9:8] leak through.

// File: rtl/wordup_pkg.sv
package wordup_pkg;
  typedef enum logic [1:0] {
    PRE_IDLE = 2'd0,
    PRE_HI   = 2'd1,
    PRE_HI0  = 2'd2
  } pre_state_t;
endpackage

// File: rtl/wu_widen.sv
module wu_widen #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic [WORD_W-1:0] raw_word,
  input  logic              narrow,
  output logic [WORD_W-1:0] wide_word,
  output logic              hi_range,
  output logic              all_zero
);
  localparam int PAD = WORD_W - NARROW_W;

  // Narrow value to full width; all-ones maps to full scale.
  function automatic logic [WORD_W-1:0] widen(input logic [NARROW_W-1:0] b);
    if (&b) return '1;
    return {b, {PAD{1'b0}}};
  endfunction

  // Any word whose top NARROW_W bits are ones counts as a high marker.
  function automatic logic in_hi(input logic [WORD_W-1:0] w);
    return &w[WORD_W-1:PAD];
  endfunction

  assign wide_word = narrow ? widen(raw_word[NARROW_W-1:0]) : raw_word;
  assign hi_range  = in_hi(wide_word);
  assign all_zero  = (wide_word == '0);

  // R5: all-ones narrow input must yield full scale
  always_comb begin
    if (narrow && (&raw_word[NARROW_W-1:0]))
      a_r5_ff_full: assert (&wide_word);
  end
endmodule

// File: rtl/wu_preamble.sv
module wu_preamble
  import wordup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hi_word,
  input  logic zero_word,
  output logic trs_hit
);
  pre_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    trs_hit = 1'b0;
    if (step) begin
      if (hi_word) begin
        state_d = PRE_HI;
      end else if (zero_word) begin
        unique case (state_q)
          PRE_HI:  state_d = PRE_HI0;
          PRE_HI0: begin state_d = PRE_IDLE; trs_hit = 1'b1; end
          default: state_d = PRE_IDLE;
        endcase
      end else begin
        state_d = PRE_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PRE_IDLE;
    else        state_q <= state_d;
  end

  // R9: a nonzero, non-high word cancels a partial preamble
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hi_word && !zero_word) |=> (state_q == PRE_IDLE));
  // R8: idle cycles leave the tracker alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
  // R7: a hit only follows a high word and one zero
  a_r7_hit_state: assert property (@(posedge clk) disable iff (!rst_n)
    trs_hit |-> (state_q == PRE_HI0));
endmodule

// File: rtl/wordup_flagger.sv
module wordup_flagger #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              in_narrow,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              anc_flag,
  output logic              trs_found
);
  localparam int PAD = WORD_W - NARROW_W;

  logic [WORD_W-1:0] wide_word;
  logic              hi_range;
  logic              all_zero;
  logic              trs_hit;

  wu_widen #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) widen_i (
    .raw_word (in_word),
    .narrow   (in_narrow),
    .wide_word(wide_word),
    .hi_range (hi_range),
    .all_zero (all_zero)
  );

  wu_preamble pre_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (in_valid),
    .hi_word  (hi_range),
    .zero_word(all_zero),
    .trs_hit  (trs_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      anc_flag  <= 1'b0;
      trs_found <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= wide_word;
      anc_flag  <= in_valid & hi_range;
      trs_found <= trs_hit;
    end
  end

  // R2: one-clock valid latency
  a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8: output word holds across idle cycles
  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
  // R6: flags only on valid output words
  a_r6_flag_valid: assert property (@(posedge clk) disable iff (!rst_n)
    anc_flag |-> (out_valid && (&out_word[WORD_W-1:PAD])));
  // R7: preamble report lands on a zero word and never with a flag
  a_r7_trs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trs_found |-> (out_valid && out_word == '0));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({anc_flag, trs_found}));
  // R4: narrow words carry zero low bits unless full scale
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_narrow) |=> ((out_word[PAD-1:0] == '0) || (&out_word)));
endmodule

// File: tb/wordup_flagger_tb.sv
module wordup_flagger_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] in_word;
  logic       in_valid;
  logic       in_narrow;
  logic [9:0] out_word;
  logic       out_valid;
  logic       anc_flag;
  logic       trs_found;

  int total = 0;
  int bad   = 0;

  // reference model state
  int m_word = 0;
  int m_st   = 0;
  bit m_flag = 0;
  bit m_trs  = 0;
  bit m_val  = 0;

  always #2 clk = ~clk;

  wordup_flagger dut_i (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_narrow(in_narrow), .out_word(out_word), .out_valid(out_valid),
    .anc_flag(anc_flag), .trs_found(trs_found)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int w, input bit n, input string tag);
    in_valid  = v;
    in_word   = w[9:0];
    in_narrow = n;
    @(posedge clk);
    #1;
    m_val = v;
    if (v) begin
      int ww;
      if (n) begin
        int b = w % 256;
        ww = (b == 255) ? 1023 : b * 4;
      end else begin
        ww = w % 1024;
      end
      m_word = ww;
      m_flag = (ww >= 1020);
      m_trs  = (m_st == 2 && ww == 0);
      if (ww >= 1020)                m_st = 1;
      else if (ww == 0 && m_st == 1) m_st = 2;
      else                           m_st = 0;
    end else begin
      m_flag = 0;
      m_trs  = 0;
    end
    check(tag, "out_valid", out_valid, m_val);
    check(tag, "out_word",  out_word,  m_word);
    check(tag, "anc_flag",  anc_flag,  m_flag);
    check(tag, "trs_found", trs_found, m_trs);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_word = 10'h3FF; in_narrow = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "out_word",  out_word,  0);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "anc_flag",  anc_flag,  0);
    check("R1", "trs_found", trs_found, 0);
    rst_n = 1'b1; in_valid = 1'b0;
    step(0, 0, 0, "R2");
    // R3: pass-through in full-width mode, R2 latency
    step(1, 'h155, 0, "R3");
    step(1, 'h2AA, 0, "R3");
    step(1, 'h3FB, 0, "R3");
    step(1, 'h001, 0, "R3");
    step(0, 'h123, 0, "R2");
    // R4: narrow widening, top input bits ignored
    step(1, 'h0A5, 1, "R4");
    step(1, 'h37F, 1, "R4");
    step(1, 'h0FE, 1, "R4");
    step(1, 'h200, 1, "R4");
    // R5: all-ones narrow word to full scale
    step(1, 'h0FF, 1, "R5");
    step(1, 'h3FF, 1, "R5");
    step(1, 'h001, 1, "R5");
    // R6: back-to-back flags across the whole high range
    step(1, 'h3FC, 0, "R6");
    step(1, 'h3FD, 0, "R6");
    step(1, 'h3FE, 0, "R6");
    step(1, 'h3FF, 0, "R6");
    step(1, 'h3FB, 0, "R6");
    // R7: preambles in both modes, plus status word in narrow mode
    step(1, 'h3FD, 0, "R7");
    step(1, 'h000, 0, "R7");
    step(1, 'h000, 0, "R7");
    step(1, 'h0FF, 1, "R7");
    step(1, 'h000, 1, "R7");
    step(1, 'h000, 1, "R7");
    step(1, 'h09D, 1, "R7");
    step(1, 'h3FB, 0, "R7");
    step(1, 'h000, 0, "R7");
    step(1, 'h000, 0, "R7");
    // R8: idle cycles inside a preamble
    step(1, 'h3FF, 0, "R8");
    step(0, 'h155, 0, "R8");
    step(1, 'h000, 0, "R8");
    step(0, 'h3FF, 0, "R8");
    step(0, 'h001, 1, "R8");
    step(1, 'h000, 0, "R8");
    // R9: cancel, restart, no second report
    step(1, 'h3FF, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h001, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h3FF, 0, "R9");
    step(1, 'h3FC, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h3FF, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h3FE, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(1, 'h000, 0, "R9");
    step(0, 0, 0, "R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule